// File: doc/BRIEF.md
# Packed Saturating Narrowing Unit

This block takes two 64-bit packed operands, called A and B, and narrows every element of both into one 64-bit packed result. Each element is clamped to the range of the narrower type. A 2-bit mode input picks one of three conversions: signed 32-bit to signed 16-bit, signed 16-bit to signed 8-bit, and signed 16-bit to unsigned 8-bit. The narrowed elements of A fill the low half of the result and those of B fill the high half. Both halves keep ascending element order.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. The pipeline has two register stages. While the consumer keeps `out_ready` high, a result appears two cycles after its operands are accepted, and a new operation can be accepted every cycle. When the output holds a result that the consumer has not taken (`out_valid` high and `out_ready` low), the whole pipeline freezes. In that state `in_ready` is low and nothing already in flight is dropped. A transfer happens on a rising clock edge where valid and ready are both high.

Top module: `pack_narrow_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both pipeline valid bits. In the cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Mode code 2'b00 narrows signed 32-bit elements to signed 16-bit. Values above 32767 become 16'h7FFF and values below -32768 become 16'h8000.
- R3: Mode code 2'b01 narrows signed 16-bit elements to signed 8-bit. Values above 127 become 8'h7F and values below -128 become 8'h80.
- R4: Mode code 2'b10 reads each 16-bit element as signed and narrows it to unsigned 8-bit. Negative values become 8'h00 and values above 255 become 8'hFF.
- R5: An element whose value fits the target type passes through unchanged, as its low-order bits.
- R6: Element i of A (bits at i times the input element width) goes to output element i. Element i of B goes to output element N+i, where N is the number of input elements per operand: 2 in mode 2'b00 and 4 in the byte modes.
- R7: While `out_ready` is high, a result appears on `out_valid`/`out_data` exactly two cycles after its operands are accepted. Back-to-back operations with different modes each give their own correct result.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay stable and `in_ready` is low. Otherwise `in_ready` is high. Every accepted operation is delivered once, in order.
- R9: Mode code 2'b11 behaves exactly like mode code 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Unit can accept operands this cycle |
| in_mode | input | 2 | Narrowing mode code |
| in_a | input | 64 | Operand A, goes to the low half of the result |
| in_b | input | 64 | Operand B, goes to the high half of the result |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Narrowed packed result |

## Verification
The main function is first tried with hand-picked vectors. These put values just inside and just outside each target range into every element position, so a wrong clamp constant or an off-by-one bound shows up. A vector of small distinct element values tells a correct element placement from a swapped or reversed half. A stream of random operands then changes mode on every cycle, which separates true per-operation mode tracking from a mode that leaks between neighbouring operations. A final phase toggles the consumer's ready at random, which tells a pipeline that freezes as a whole from one that drops or duplicates results under back-pressure.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

  typedef enum logic [1:0] {
    NM_S32_S16 = 2'b00,
    NM_S16_S8  = 2'b01,
    NM_S16_U8  = 2'b10,
    NM_ALIAS   = 2'b11
  } nmode_e;

  // signed doubleword -> signed word with clamping
  function automatic logic [15:0] clamp_s16(input logic [31:0] d);
    logic fits;
    fits = (&d[31:15]) | ~(|d[31:15]);
    if (fits)       return d[15:0];
    else if (d[31]) return 16'h8000;
    else            return 16'h7FFF;
  endfunction

  // signed word -> signed byte with clamping
  function automatic logic [7:0] clamp_s8(input logic [15:0] w);
    logic fits;
    fits = (&w[15:7]) | ~(|w[15:7]);
    if (fits)       return w[7:0];
    else if (w[15]) return 8'h80;
    else            return 8'h7F;
  endfunction

  // signed word -> unsigned byte with clamping
  function automatic logic [7:0] clamp_u8(input logic [15:0] w);
    if (w[15])          return 8'h00;
    else if (|w[14:8])  return 8'hFF;
    else                return w[7:0];
  endfunction

endpackage

// File: rtl/sat_narrow_dw.sv
module sat_narrow_dw
  import narrow_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int NDW = W / 32;

  for (genvar i = 0; i < NDW; i++) begin : g_lane
    assign y[16*i +: 16]         = clamp_s16(a[32*i +: 32]);
    assign y[16*(NDW+i) +: 16]   = clamp_s16(b[32*i +: 32]);
  end
endmodule

// File: rtl/sat_narrow_w.sv
module sat_narrow_w
  import narrow_pkg::*;
#(
  parameter int W        = 64,
  parameter bit UNS_OUT  = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int NW = W / 16;

  for (genvar i = 0; i < NW; i++) begin : g_lane
    if (UNS_OUT) begin : g_uns
      assign y[8*i +: 8]        = clamp_u8(a[16*i +: 16]);
      assign y[8*(NW+i) +: 8]   = clamp_u8(b[16*i +: 16]);
    end else begin : g_sgn
      assign y[8*i +: 8]        = clamp_s8(a[16*i +: 16]);
      assign y[8*(NW+i) +: 8]   = clamp_s8(b[16*i +: 16]);
    end
  end
endmodule

// File: rtl/pack_narrow_unit.sv
module pack_narrow_unit
  import narrow_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_mode,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int HALF = W / 2;

  // stage 1: registered operands
  logic         s1_valid;
  nmode_e       s1_mode;
  logic [W-1:0] s1_a, s1_b;
  // stage 2: registered result
  logic         s2_valid;
  logic [W-1:0] s2_data;

  logic         adv;
  logic [W-1:0] y_dw, y_s8, y_u8, y_sel;

  assign adv      = !(s2_valid && !out_ready);
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_mode <= nmode_e'(in_mode);
      s1_a    <= in_a;
      s1_b    <= in_b;
    end
  end

  sat_narrow_dw #(.W(W)) u_dw (.a(s1_a), .b(s1_b), .y(y_dw));
  sat_narrow_w  #(.W(W), .UNS_OUT(1'b0)) u_s8 (.a(s1_a), .b(s1_b), .y(y_s8));
  sat_narrow_w  #(.W(W), .UNS_OUT(1'b1)) u_u8 (.a(s1_a), .b(s1_b), .y(y_u8));

  always_comb begin
    unique case (s1_mode)
      NM_S16_S8: y_sel = y_s8;
      NM_S16_U8: y_sel = y_u8;
      default:   y_sel = y_dw;   // word mode and its alias code
    endcase
  end

  always_ff @(posedge clk) begin
    if (adv && s1_valid) s2_data <= y_sel;
  end

  assign out_valid = s2_valid;
  assign out_data  = s2_data;

  // ---------------- assertions ----------------
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !s1_valid));

  assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_valid);

  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && out_ready) |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_valid && s1_mode == NM_S32_S16 && !s1_a[31] && (|s1_a[30:15]))
      |=> out_data[15:0] == 16'h7FFF);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_valid && s1_mode == NM_S16_U8 && s1_a[15])
      |=> out_data[7:0] == 8'h00);

  assert_hi_half_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && s1_valid && s1_mode == NM_S16_S8 && !(|s1_b[15:7]))
      |=> out_data[HALF +: 8] == $past(s1_b[7:0]));
endmodule

// File: tb/pack_narrow_unit_tb.sv
module pack_narrow_unit_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [1:0]   in_mode;
  logic [W-1:0] in_a, in_b, out_data;

  always #10 clk = ~clk;

  pack_narrow_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [63:0] q_exp[$];
  string       q_tag[$];
  int          q_cyc[$];
  bit          strict_lat = 1'b0;
  bit          prev_hold  = 1'b0;
  logic [63:0] prev_data;

  function automatic logic [7:0] ref_b(input int v, input bit uns);
    int r;
    if (uns) r = (v < 0) ? 0 : (v > 255) ? 255 : v;
    else     r = (v < -128) ? -128 : (v > 127) ? 127 : v;
    return 8'(r);
  endfunction

  function automatic logic [15:0] ref_w(input longint v);
    longint r;
    r = (v < -32768) ? -32768 : (v > 32767) ? 32767 : v;
    return 16'(r);
  endfunction

  function automatic logic [63:0] ref_narrow(input logic [1:0] m,
                                             input logic [63:0] a, b);
    logic [63:0] r;
    r = '0;
    if (m == 2'b01 || m == 2'b10) begin
      for (int i = 0; i < 4; i++) begin
        r[8*i +: 8]     = ref_b(int'($signed(a[16*i +: 16])), m == 2'b10);
        r[8*(4+i) +: 8] = ref_b(int'($signed(b[16*i +: 16])), m == 2'b10);
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        r[16*i +: 16]     = ref_w(longint'($signed(a[32*i +: 32])));
        r[16*(2+i) +: 16] = ref_w(longint'($signed(b[32*i +: 32])));
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, observe 1 ns later, advance to next negedge
  task automatic step(input logic iv, input logic [1:0] m,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic ordy, input bit use_exp,
                      input logic [63:0] exp_v, input string tag);
    logic [63:0] e;
    in_valid = iv; in_mode = m; in_a = a; in_b = b; out_ready = ordy;
    #1;
    if (prev_hold) begin
      chk("R8 held valid", 64'(out_valid), 64'd1);
      chk("R8 held data", out_data, prev_data);
    end
    chk("R8 in_ready", 64'(in_ready), 64'(!(out_valid && !out_ready)));
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) chk("R8 unexpected output", 64'd1, 64'd0);
      else begin
        chk(q_tag[0], out_data, q_exp[0]);
        if (strict_lat) chk("R7 latency", 64'(cyc - q_cyc[0]), 64'd2);
        void'(q_exp.pop_front()); void'(q_tag.pop_front()); void'(q_cyc.pop_front());
      end
    end else if (!out_valid && strict_lat && q_exp.size() > 0 && q_cyc[0] + 2 <= cyc) begin
      chk("R7 result late", 64'd0, 64'd1);
      void'(q_exp.pop_front()); void'(q_tag.pop_front()); void'(q_cyc.pop_front());
    end
    if (iv && in_ready) begin
      e = use_exp ? exp_v : ref_narrow(m, a, b);
      q_exp.push_back(e);
      q_tag.push_back(tag);
      q_cyc.push_back(cyc);
    end
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 2'b00, '0, '0, 1'b1, 1'b0, '0, "idle");
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [1:0]  m;
    logic [63:0] a, b;
    rst = 1'b1; in_valid = 1'b0; in_mode = '0; in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);

    strict_lat = 1'b1;
    // R2: clamp both directions, and exact bounds from B
    step(1, 2'b00, 64'hFFFE0000_00010000, 64'hFFFF8000_00007FFF, 1, 1,
         64'h8000_7FFF_8000_7FFF, "R2 word clamp");
    // R5: in-range values pass through
    step(1, 2'b00, 64'hFFFFFFFF_00001234, 64'hFFFF8001_00000000, 1, 1,
         64'h8001_0000_FFFF_1234, "R5 word passthrough");
    // R3: signed byte clamp at bounds
    step(1, 2'b01, 64'h8000_FF80_007F_0080, 64'h0100_FF7F_0005_FFFF, 1, 1,
         64'h7F8005FF_80807F7F, "R3 signed byte clamp");
    // R4: unsigned byte clamp from signed words
    step(1, 2'b10, 64'h8000_0100_00FF_FFFF, 64'h7FFF_0001_0000_0080, 1, 1,
         64'hFF010080_00FFFF00, "R4 unsigned byte clamp");
    // R6: element placement
    step(1, 2'b01, 64'h0004_0003_0002_0001, 64'h0014_0013_0012_0011, 1, 1,
         64'h14131211_04030201, "R6 placement bytes");
    step(1, 2'b00, 64'h00000022_00000011, 64'h00000044_00000033, 1, 1,
         64'h0044_0033_0022_0011, "R6 placement words");
    // R9: alias code behaves like word mode
    step(1, 2'b11, 64'hFFFE0000_00010000, 64'hFFFF8000_00007FFF, 1, 1,
         64'h8000_7FFF_8000_7FFF, "R9 alias code");
    // R7: back-to-back mixed modes
    for (int k = 0; k < 60; k++) begin
      m = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 3 == 0) begin a = a & 64'h01FF_01FF_01FF_01FF; b = b | 64'hFF00_0000_FF00_0000; end
      step(1, m, a, b, 1, 0, '0, $sformatf("R7 %s mixed", mode_tag(m)));
    end
    idle(4);
    chk("R7 drained", 64'(q_exp.size()), 64'd0);

    // R8: random back-pressure
    strict_lat = 1'b0;
    for (int k = 0; k < 150; k++) begin
      m = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      step(1'($urandom_range(0, 1)), m, a, b, 1'($urandom_range(0, 2) != 0), 0, '0,
           $sformatf("R8 %s stalled", mode_tag(m)));
    end
    idle(6);
    chk("R8 nothing lost", 64'(q_exp.size()), 64'd0);

    // R1: reset in the middle of traffic
    step(1, 2'b01, 64'h1, 64'h2, 1, 0, '0, "R1 pre");
    step(1, 2'b10, 64'h3, 64'h4, 1, 0, '0, "R1 pre");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q_exp.delete(); q_tag.delete(); q_cyc.delete();
    prev_hold = 1'b0;
    #1;
    chk("R1 mid-run out_valid", 64'(out_valid), 64'd0);
    chk("R1 mid-run in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    #1;
    chk("R1 no stale result", 64'(out_valid), 64'd0);
    summary();
  end
endmodule